// File: doc/BRIEF.md
# Multicycle Byte-Wide Processor Core

This block is a small 8-bit processor core. It runs each instruction over several short clock cycles instead of one long one. Each instruction is one byte. The register file holds four 8-bit registers, k0 to k3. Two flags, zero and negative, are updated by the arithmetic and logic instructions and tested by the conditional branches. Instructions and data sit in separate memories. The core reads instruction bytes through a fetch port and reads or writes data bytes through a data port. Both memories are outside the block and answer combinationally in the same cycle.

A 4-bit sequencer steps through the cycles of each instruction. The first cycle fetches the instruction into an instruction holding register and advances the program counter. The second cycle reads both operand registers into temporaries. Any later cycles depend on the opcode: an ALU cycle into a result holding register, a memory cycle into a memory-data holding register, a write-back cycle, or a branch update. One variant of load also bumps its address register after the load. The `fetch_o` output marks the first cycle of every instruction, so the surrounding system can count instructions and their lengths.

Top module: `mcpu_core`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the core is in its fetch cycle: `imem_addr` = 0x80 and `fetch_o` = 1, with no data strobe. Reset clears all four registers and both flags to zero.
- R2: In every fetch cycle `fetch_o` is 1 and the byte on `imem_data` at `imem_addr` is captured as the instruction. The program counter then advances by one (modulo 256), and the next cycle is never a fetch cycle.
- R3: Register-register ALU ops are selected by bits [3:0]: 0100 add, 0110 subtract, 1000 NAND. Each computes k[7:6] op k[5:4], writes the result into k[7:6], and takes 4 cycles.
- R4: Add, subtract, NAND, shift and OR-immediate set the zero flag when their 8-bit result is 0 and copy result bit 7 into the negative flag. Load, store, branches and no-ops leave both flags unchanged.
- R5: Bits [2:0] = 011 select a shift of k[7:6] by bits [4:3]. If bit 5 is 1 the shift is to the left; if bit 5 is 0 it is a logical shift to the right. The result goes back into k[7:6], and the instruction takes 4 cycles.
- R6: Bits [2:0] = 111 select an OR of k1 with the zero-extended bits [7:3]. The result goes into k1, and the instruction takes 5 cycles: read k1, compute, write.
- R7: Opcode 0000 loads the byte at address k[5:4] into k[7:6] and takes 4 cycles. In cycle 3, `dmem_re` = 1 with `dmem_addr` = k[5:4].
- R8: Opcode 0010 stores k[7:6] to address k[5:4] and takes 3 cycles. In cycle 3, `dmem_we` = 1, with `dmem_addr` = k[5:4] and `dmem_wdata` = k[7:6].
- R9: Opcodes 0101, 1001 and 1101 are branches. They branch when zero = 1, when zero = 0, and when negative = 0 respectively. A taken branch adds the sign-extended bits [7:4] to the already incremented program counter. Branches take 3 cycles.
- R10: Opcode 1010 is a post-increment load. It writes the byte at address k[5:4] into k[7:6] in cycle 4, then writes the original k[5:4] plus one into k[5:4] in cycle 5. It takes 5 cycles.
- R11: When a post-increment load names the same register in both fields, the loaded byte is kept and the increment is dropped.
- R12: Opcodes 0001, 1100 and 1110 take 2 cycles and change no register, flag or memory.
- R13: `dmem_re` and `dmem_we` are never both high. Either one is high only in the third cycle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction address (program counter) |
| imem_data | input | 8 | Instruction byte at `imem_addr`, combinational |
| dmem_addr | output | 8 | Data address |
| dmem_wdata | output | 8 | Store data |
| dmem_re | output | 1 | Data read strobe; the read byte is captured at the end of the cycle |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | 8 | Data byte at `dmem_addr`, combinational |
| fetch_o | output | 1 | High in the first (fetch) cycle of each instruction |

## Verification
The bench builds the core with its default parameters: an 8-bit word, four registers and a start address of 0x80. With these values the whole instruction and data spaces are only 256 bytes each. Random programs therefore wrap the program counter past 0xFF, reuse data addresses, and hit every one of the 16 low-nibble opcodes with many register pairings. A directed program adds the corner cases: a post-increment load into its own address register, shifts in both directions, a skipped no-op under a taken branch, and a not-taken branch.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int W     = 8;
    localparam int NREG  = 4;
    localparam int RA_W  = $clog2(NREG);
    localparam int OP_W  = 4;

    // low-nibble opcodes decoded by the sequencer
    localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0000;
    localparam logic [OP_W-1:0] OPC_STORE = 4'b0010;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'b0100;
    localparam logic [OP_W-1:0] OPC_SUB   = 4'b0110;
    localparam logic [OP_W-1:0] OPC_NAND  = 4'b1000;
    localparam logic [OP_W-1:0] OPC_LDINC = 4'b1010;
    localparam logic [OP_W-1:0] OPC_BZ    = 4'b0101;
    localparam logic [OP_W-1:0] OPC_BNZ   = 4'b1001;
    localparam logic [OP_W-1:0] OPC_BPZ   = 4'b1101;
    localparam logic [2:0]      SUB_SHIFT = 3'b011;
    localparam logic [2:0]      SUB_ORI   = 3'b111;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_SHIFT, ST_WB_ALU,
        ST_ORI_RD, ST_ORI_EXEC, ST_ORI_WB,
        ST_LD_MEM, ST_LD_WB, ST_INC_WB, ST_STORE, ST_BRANCH
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_OR, ALU_NAND, ALU_SHL, ALU_SHR
    } alu_op_e;

    typedef enum logic [1:0] { BSEL_REG, BSEL_IMM3, BSEL_IMM5 } bsel_e;
    typedef enum logic [1:0] { WA_DST, WA_SRC, WA_K1 } wasel_e;
    typedef enum logic [1:0] { WD_ALU, WD_MDR, WD_INC } wdsel_e;

    typedef struct packed {
        logic    fetch;
        logic    rd_regs;
        logic    rd_k1;
        logic    alu_en;
        alu_op_e alu_op;
        bsel_e   bsel;
        logic    rf_we;
        wasel_e  wa;
        wdsel_e  wd;
        logic    mem_re;
        logic    mem_we;
        logic    br_take;
    } ctrl_t;

    typedef struct packed {
        logic [W-1:0] pc;
        logic [W-1:0] ir;
        logic [W-1:0] mdr;
        logic [W-1:0] r1;
        logic [W-1:0] r2;
        logic [W-1:0] alu;
        logic         z;
        logic         n;
    } dp_t;

endpackage

// File: rtl/mcpu_rf.sv
module mcpu_rf #(
    parameter int W    = 8,
    parameter int NREG = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs_q [NREG];
    logic [W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
(
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         neg
);

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_OR:   y = a | b;
            ALU_NAND: y = ~(a & b);
            ALU_SHL:  y = a << b[1:0];
            ALU_SHR:  y = a >> b[1:0];
            default:  y = '0;
        endcase
        zero = (y == '0);
        neg  = y[W-1];
    end

endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
    import mcpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op,
    input  logic            shl,
    input  logic            same_reg,
    input  logic            z,
    input  logic            n,
    output ctrl_t           ctl
);

    state_e state_q, state_d;

    always_comb begin
        state_d = ST_FETCH;
        ctl     = '0;
        unique case (state_q)
            ST_FETCH: begin
                ctl.fetch = 1'b1;
                state_d   = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.rd_regs = 1'b1;
                if (op[2:0] == SUB_ORI)        state_d = ST_ORI_RD;
                else if (op[2:0] == SUB_SHIFT) state_d = ST_SHIFT;
                else begin
                    case (op)
                        OPC_ADD, OPC_SUB, OPC_NAND:   state_d = ST_EXEC;
                        OPC_LOAD, OPC_LDINC:          state_d = ST_LD_MEM;
                        OPC_STORE:                    state_d = ST_STORE;
                        OPC_BZ, OPC_BNZ, OPC_BPZ:     state_d = ST_BRANCH;
                        default:                      state_d = ST_FETCH;
                    endcase
                end
            end
            ST_EXEC: begin
                ctl.alu_en = 1'b1;
                ctl.bsel   = BSEL_REG;
                case (op)
                    OPC_SUB:  ctl.alu_op = ALU_SUB;
                    OPC_NAND: ctl.alu_op = ALU_NAND;
                    default:  ctl.alu_op = ALU_ADD;
                endcase
                state_d = ST_WB_ALU;
            end
            ST_SHIFT: begin
                ctl.alu_en = 1'b1;
                ctl.bsel   = BSEL_IMM3;
                ctl.alu_op = shl ? ALU_SHL : ALU_SHR;
                state_d    = ST_WB_ALU;
            end
            ST_WB_ALU: begin
                ctl.rf_we = 1'b1;
                ctl.wa    = WA_DST;
                ctl.wd    = WD_ALU;
            end
            ST_ORI_RD: begin
                ctl.rd_k1 = 1'b1;
                state_d   = ST_ORI_EXEC;
            end
            ST_ORI_EXEC: begin
                ctl.alu_en = 1'b1;
                ctl.bsel   = BSEL_IMM5;
                ctl.alu_op = ALU_OR;
                state_d    = ST_ORI_WB;
            end
            ST_ORI_WB: begin
                ctl.rf_we = 1'b1;
                ctl.wa    = WA_K1;
                ctl.wd    = WD_ALU;
            end
            ST_LD_MEM: begin
                ctl.mem_re = 1'b1;
                state_d    = ST_LD_WB;
            end
            ST_LD_WB: begin
                ctl.rf_we = 1'b1;
                ctl.wa    = WA_DST;
                ctl.wd    = WD_MDR;
                state_d   = (op == OPC_LDINC) ? ST_INC_WB : ST_FETCH;
            end
            ST_INC_WB: begin
                // loaded value wins when both fields name one register
                ctl.rf_we = !same_reg;
                ctl.wa    = WA_SRC;
                ctl.wd    = WD_INC;
            end
            ST_STORE: begin
                ctl.mem_we = 1'b1;
            end
            ST_BRANCH: begin
                case (op)
                    OPC_BZ:  ctl.br_take = z;
                    OPC_BNZ: ctl.br_take = !z;
                    default: ctl.br_take = !n;
                endcase
            end
            default: state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter logic [W-1:0] RESET_PC = 8'h80
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] imem_addr,
    input  logic [W-1:0] imem_data,
    output logic [W-1:0] dmem_addr,
    output logic [W-1:0] dmem_wdata,
    output logic         dmem_re,
    output logic         dmem_we,
    input  logic [W-1:0] dmem_rdata,
    output logic         fetch_o
);

    localparam logic [RA_W-1:0] K1_IDX = RA_W'(1);

    dp_t   dp_q, dp_d;
    ctrl_t ctl;

    logic [RA_W-1:0] dst_idx, src_idx, ra1, wa;
    logic [W-1:0]    rd1, rd2, wd, alu_b, alu_y, br_off;
    logic            alu_z, alu_n;

    assign dst_idx = dp_q.ir[7:6];
    assign src_idx = dp_q.ir[5:4];
    assign ra1     = ctl.rd_k1 ? K1_IDX : dst_idx;
    assign br_off  = {{(W-4){dp_q.ir[7]}}, dp_q.ir[7:4]};

    mcpu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (dp_q.ir[3:0]),
        .shl      (dp_q.ir[5]),
        .same_reg (dst_idx == src_idx),
        .z        (dp_q.z),
        .n        (dp_q.n),
        .ctl      (ctl)
    );

    always_comb begin
        unique case (ctl.bsel)
            BSEL_IMM3: alu_b = W'(dp_q.ir[4:3]);
            BSEL_IMM5: alu_b = W'(dp_q.ir[7:3]);
            default:   alu_b = dp_q.r2;
        endcase
        unique case (ctl.wa)
            WA_SRC:  wa = src_idx;
            WA_K1:   wa = K1_IDX;
            default: wa = dst_idx;
        endcase
        unique case (ctl.wd)
            WD_MDR:  wd = dp_q.mdr;
            WD_INC:  wd = dp_q.r2 + W'(1);
            default: wd = dp_q.alu;
        endcase
    end

    mcpu_alu u_alu (
        .op   (ctl.alu_op),
        .a    (dp_q.r1),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_z),
        .neg  (alu_n)
    );

    mcpu_rf #(.W(W), .NREG(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ra1),
        .ra2 (src_idx),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (ctl.rf_we),
        .wa  (wa),
        .wd  (wd)
    );

    always_comb begin
        dp_d = dp_q;
        if (ctl.fetch) begin
            dp_d.ir = imem_data;
            dp_d.pc = dp_q.pc + W'(1);
        end
        if (ctl.rd_regs) begin
            dp_d.r1 = rd1;
            dp_d.r2 = rd2;
        end
        if (ctl.rd_k1)   dp_d.r1 = rd1;
        if (ctl.alu_en) begin
            dp_d.alu = alu_y;
            dp_d.z   = alu_z;
            dp_d.n   = alu_n;
        end
        if (ctl.mem_re)  dp_d.mdr = dmem_rdata;
        if (ctl.br_take) dp_d.pc  = dp_q.pc + br_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q    <= '0;
            dp_q.pc <= RESET_PC;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign imem_addr  = dp_q.pc;
    assign dmem_addr  = dp_q.r2;
    assign dmem_wdata = dp_q.r1;
    assign dmem_re    = ctl.mem_re;
    assign dmem_we    = ctl.mem_we;
    assign fetch_o    = ctl.fetch;

endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk
    import mcpu_pkg::*;
#(
    parameter logic [W-1:0] RESET_PC = 8'h80
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] imem_addr,
    input logic         dmem_re,
    input logic         dmem_we,
    input logic         fetch_o
);

    // R1: a reset cycle leaves the core fetching from the start address
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == RESET_PC && fetch_o && !dmem_we && !dmem_re));

    // R2: fetch is followed by a non-fetch cycle
    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
        fetch_o |=> !fetch_o);

    // R2: program counter advances by one after fetch
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        fetch_o |=> (imem_addr == $past(imem_addr) + W'(1)));

    // R7: load continues to a write-back cycle after its read
    p_load_wb_r7: assert property (@(posedge clk) disable iff (rst)
        dmem_re |=> !fetch_o);

    // R8: store ends in the cycle of its write
    p_store_last_r8: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> fetch_o);

    // R13: strobes exclusive
    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && dmem_re));

    // R13: strobes occur only two cycles after a fetch
    p_strobe_cycle3_r13: assert property (@(posedge clk) disable iff (rst)
        (dmem_we || dmem_re) |-> $past(fetch_o, 2));

endmodule

bind mcpu_core mcpu_core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_re   (dmem_re),
    .dmem_we   (dmem_we),
    .fetch_o   (fetch_o)
);

// File: tb/mcpu_core_test.sv
module mcpu_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic       dmem_re, dmem_we, fetch_o;

    logic [7:0] imem  [256];
    logic [7:0] dmem  [256];
    logic [7:0] dinit [256];

    // bench reference model state
    logic [7:0] mdm [256];
    logic [7:0] mk  [4];
    logic       mz, mn;
    logic [7:0] mpc;
    int         exp_len, cyc, nfetch, rcnt;
    bit         pend, exp_st, exp_ld, run;
    logic [7:0] sa, sd, la;
    string      ptag;
    int         nchk = 0, nerr = 0;

    always #2.5 clk = ~clk;

    mcpu_core uut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_re(dmem_re),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata), .fetch_o(fetch_o)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) dmem[i] <= dinit[i];
        end else if (dmem_we) begin
            dmem[dmem_addr] <= dmem_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [7:0] enc_rr(input logic [3:0] op, input logic [1:0] a, input logic [1:0] b);
        return {a, b, op};
    endfunction
    function automatic logic [7:0] enc_ori(input logic [4:0] imm);
        return {imm, 3'b111};
    endfunction
    function automatic logic [7:0] enc_sh(input logic [1:0] a, input logic left, input logic [1:0] amt);
        return {a, left, amt, 3'b011};
    endfunction
    function automatic logic [7:0] enc_br(input logic [3:0] op, input logic [3:0] off);
        return {off, op};
    endfunction

    task automatic set_flags(input logic [7:0] r);
        mz = (r == 8'h00);
        mn = r[7];
    endtask

    // reference step: architectural effect, cycle count and expected strobes
    task automatic model_step(input logic [7:0] ins);
        logic [1:0] a, b;
        logic [7:0] r, off;
        a = ins[7:6]; b = ins[5:4];
        off = {{4{ins[7]}}, ins[7:4]};
        exp_st = 0; exp_ld = 0;
        mpc = mpc + 8'd1;
        if (ins[2:0] == 3'b111) begin
            r = mk[1] | {3'b000, ins[7:3]}; mk[1] = r; set_flags(r);
            exp_len = 5; ptag = "R6";
        end else if (ins[2:0] == 3'b011) begin
            r = ins[5] ? (mk[a] << ins[4:3]) : (mk[a] >> ins[4:3]);
            mk[a] = r; set_flags(r); exp_len = 4; ptag = "R5";
        end else begin
            case (ins[3:0])
                4'b0100: begin r = mk[a] + mk[b]; mk[a] = r; set_flags(r); exp_len = 4; ptag = "R3"; end
                4'b0110: begin r = mk[a] - mk[b]; mk[a] = r; set_flags(r); exp_len = 4; ptag = "R3"; end
                4'b1000: begin r = ~(mk[a] & mk[b]); mk[a] = r; set_flags(r); exp_len = 4; ptag = "R3"; end
                4'b0000: begin
                    exp_ld = 1; la = mk[b]; mk[a] = mdm[la]; exp_len = 4; ptag = "R7";
                end
                4'b1010: begin
                    exp_ld = 1; la = mk[b]; r = mk[b] + 8'd1;
                    mk[a] = mdm[la];
                    if (a != b) begin mk[b] = r; ptag = "R10"; end
                    else ptag = "R11";
                    exp_len = 5;
                end
                4'b0010: begin
                    exp_st = 1; sa = mk[b]; sd = mk[a]; mdm[sa] = sd; exp_len = 3; ptag = "R8";
                end
                4'b0101: begin if (mz)  mpc = mpc + off; exp_len = 3; ptag = "R9,R4"; end
                4'b1001: begin if (!mz) mpc = mpc + off; exp_len = 3; ptag = "R9,R4"; end
                4'b1101: begin if (!mn) mpc = mpc + off; exp_len = 3; ptag = "R9,R4"; end
                default: begin exp_len = 2; ptag = "R12"; end
            endcase
        end
    endtask

    always @(negedge clk) begin
        if (rst || !run) begin
            rcnt++;
            if (rst && rcnt == 2)
                chk(imem_addr == 8'h80 && fetch_o && !dmem_we && !dmem_re, "R1", "reset state",
                    {fetch_o, dmem_we, dmem_re, imem_addr}, {3'b100, 8'h80});
            for (int i = 0; i < 4; i++) mk[i] = 8'h00;
            for (int i = 0; i < 256; i++) mdm[i] = dinit[i];
            mz = 0; mn = 0; mpc = 8'h80;
            pend = 0; cyc = 0; nfetch = 0; exp_st = 0; exp_ld = 0;
        end else begin
            rcnt = 0;
            if (fetch_o) begin
                if (pend) chk(cyc == exp_len, ptag, "instruction length", cyc, exp_len);
                chk(imem_addr == mpc, pend ? ptag : "R1", "R2 fetch address", imem_addr, mpc);
                model_step(imem[imem_addr]);
                pend = 1; cyc = 1; nfetch++;
            end else begin
                cyc++;
                if (cyc == 8) chk(0, ptag, "no fetch seen (hang)", cyc, exp_len);
            end
            if (cyc == 3 && exp_st)
                chk(dmem_we && !dmem_re && dmem_addr == sa && dmem_wdata == sd, "R8",
                    "store strobe addr/data", {dmem_we, dmem_addr, dmem_wdata}, {1'b1, sa, sd});
            else if (cyc == 3 && exp_ld)
                chk(dmem_re && !dmem_we && dmem_addr == la, ptag,
                    "R7 load strobe addr", {dmem_re, dmem_addr}, {1'b1, la});
            else
                chk(!dmem_we && !dmem_re, "R13", "unexpected strobe", {dmem_we, dmem_re}, 0);
        end
    end

    task automatic run_prog(input int count);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0; run = 1'b1;
        wait (nfetch >= count);
        @(posedge clk);
        #1 rst = 1'b1; run = 1'b0;
    endtask

    initial begin
        logic [7:0] prog [21];
        run = 1'b0;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 256; i++) begin
            imem[i]  = 8'($urandom);
            dinit[i] = 8'($urandom);
        end
        // directed corner cases
        prog[0]  = enc_ori(5'd5);                 // R6: k1 = 5
        prog[1]  = enc_rr(4'b0100, 2'd0, 2'd1);   // R3: k0 = 5
        prog[2]  = enc_ori(5'h1f);                // R6: k1 = 0x1f
        prog[3]  = enc_sh(2'd1, 1'b1, 2'd3);      // R5: left, k1 = 0xf8, N = 1
        prog[4]  = enc_rr(4'b0110, 2'd2, 2'd1);   // R3: k2 = 0x08
        prog[5]  = enc_rr(4'b1000, 2'd3, 2'd3);   // R3: k3 = 0xff
        prog[6]  = enc_rr(4'b0010, 2'd3, 2'd0);   // R8: mem[5] = 0xff
        prog[7]  = enc_rr(4'b1010, 2'd2, 2'd0);   // R10: k2 = 0xff, k0 = 6
        prog[8]  = enc_rr(4'b1010, 2'd0, 2'd0);   // R11: k0 = mem[6], no increment
        prog[9]  = enc_sh(2'd3, 1'b0, 2'd2);      // R5: right, k3 = 0x3f
        prog[10] = enc_rr(4'b0110, 2'd1, 2'd1);   // R4: k1 = 0, Z = 1
        prog[11] = enc_br(4'b0101, 4'd1);         // R9: taken, skips next
        prog[12] = 8'h0C;                         // R12: skipped
        prog[13] = enc_br(4'b1001, 4'd2);         // R9: not taken
        prog[14] = 8'h0E;                         // R12: no-op
        prog[15] = enc_br(4'b1101, 4'd0);         // R9: taken, offset 0
        prog[16] = enc_rr(4'b0010, 2'd0, 2'd1);   // R8 dumps
        prog[17] = enc_rr(4'b0010, 2'd1, 2'd2);
        prog[18] = enc_rr(4'b0010, 2'd2, 2'd3);
        prog[19] = enc_rr(4'b0010, 2'd3, 2'd0);
        prog[20] = 8'h01;                         // R12
        for (int i = 0; i < 21; i++) imem[8'h80 + i] = prog[i];
        run_prog(20);

        // constrained random programs
        for (int p = 0; p < 24; p++) begin
            for (int i = 0; i < 256; i++) begin
                imem[i]  = 8'($urandom);
                dinit[i] = 8'($urandom);
            end
            run_prog(250);
        end
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
        $finish;
    end

endmodule